// File: doc/BRIEF.md
# Self-Correcting Periodic Branch Predictor

This block predicts the outcome of a conditional branch whose behaviour repeats with a fixed period of five: taken, not-taken, taken, taken, not-taken. The expected sequence is held in a circular register. The prediction output is the head of that register. It is combinational and valid in the cycle before the branch strobe samples the resolved outcome.

Each strobed branch rotates the register by one position. When the resolved outcome disagrees with the prediction, every stored bit is also inverted on the same clock edge. A stream that follows the complemented sequence therefore costs one miss, and all later predictions match it. A stream that follows the stored sequence is predicted with no misses at all. Taken is encoded as 1 and not-taken as 0.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the register leaves its reset value two clock edges after the reset input goes high. Branch strobes that arrive before then are ignored.

Top module: `periodic_branch_predictor`

## Requirements
- R1: While reset is held, and after it is released, the register contains 1,0,1,1,0 from head to tail, so the prediction output is 1 for the first branch.
- R2: The prediction output always equals the head bit of the register. With every outcome equal to the prediction, successive strobed branches see the predictions 1,0,1,1,0 and then the same five values again.
- R3: On a strobed branch whose outcome equals the prediction, the register rotates by one position toward the head: the old head re-enters at the tail, and no bit value changes.
- R4: On a strobed branch whose outcome differs from the prediction, the register rotates and every bit is inverted, both in that one clock edge.
- R5: While the strobe is low, the register holds its value and the outcome input has no effect on any later prediction.
- R6: Fed the stored sequence directly after reset, the block mispredicts no branch, starting with the first.
- R7: Fed the complemented sequence directly after reset, the block mispredicts the first branch only.
- R8: The register always holds exactly three or exactly two ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| br_valid | input | 1 | Strobe: a conditional branch resolves on this clock edge |
| br_taken | input | 1 | Resolved outcome, 1 for taken; sampled only while br_valid is high |
| pred_taken | output | 1 | Prediction for the next strobed branch, 1 for taken |

## Verification
A prediction is due in the same cycle that its strobe is driven, because it comes straight from the register head. The effect of a resolved outcome, whether a rotation or a rotation with inversion, first shows on the output one clock edge later. The driver samples the bench's own model when it raises the strobe and pushes that expected prediction into a queue. The monitor pops and compares it half a low phase after the driving falling edge, so the check sits before the rising edge that consumes the outcome. After a reset the bench waits for the two-edge release before it checks anything. Idle periods are checked by reading the output directly once the outcome input has toggled with the strobe low.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // Default period of the tracked outcome stream.
  localparam int unsigned PAT_LEN_DEF = 5;
  // Head is the MSB: T, NT, T, T, NT.
  localparam logic [PAT_LEN_DEF-1:0] PAT_DEF = 5'b10110;
  // Reset release synchroniser depth.
  localparam int unsigned RST_STAGES_DEF = 2;

  typedef enum logic {
    OUT_NOT_TAKEN = 1'b0,
    OUT_TAKEN     = 1'b1
  } outcome_e;
endpackage

// File: rtl/bp_reset_sync.sv
module bp_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bp_miss_detect.sv
module bp_miss_detect (
  input  logic valid,
  input  logic outcome,
  input  logic guess,
  output logic miss
);
  always_comb begin
    miss = valid & (outcome ^ guess);
  end
endmodule

// File: rtl/bp_pattern_ring.sv
module bp_pattern_ring #(
  parameter int unsigned        LEN  = 5,
  parameter logic [LEN-1:0]     INIT = 5'b10110
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic           flip,
  output logic           head,
  output logic [LEN-1:0] state
);
  logic [LEN-1:0] ring_q;
  logic [LEN-1:0] ring_d;
  logic [LEN-1:0] rotated;

  always_comb begin
    rotated = {ring_q[LEN-2:0], ring_q[LEN-1]};
    ring_d  = ring_q;
    if (advance) begin
      ring_d = flip ? ~rotated : rotated;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_q <= INIT;
    else if (advance) ring_q <= ring_d;
  end

  assign head  = ring_q[LEN-1];
  assign state = ring_q;
endmodule

// File: rtl/periodic_branch_predictor.sv
module periodic_branch_predictor
  import bp_pkg::*;
#(
  parameter int unsigned          PAT_LEN    = PAT_LEN_DEF,
  parameter logic [PAT_LEN-1:0]   PAT        = PAT_DEF,
  parameter int unsigned          RST_STAGES = RST_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic br_valid,
  input  logic br_taken,
  output logic pred_taken
);
  logic               rst_n_q;
  logic               miss;
  logic               head;
  logic [PAT_LEN-1:0] ring_state;

  bp_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  bp_miss_detect u_miss (
    .valid   (br_valid),
    .outcome (br_taken),
    .guess   (head),
    .miss    (miss)
  );

  bp_pattern_ring #(.LEN(PAT_LEN), .INIT(PAT)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .advance (br_valid),
    .flip    (miss),
    .head    (head),
    .state   (ring_state)
  );

  assign pred_taken = head;
endmodule

// File: rtl/periodic_branch_predictor_chk.sv
module periodic_branch_predictor_chk #(
  parameter int unsigned        LEN = 5,
  parameter logic [LEN-1:0]     PAT = 5'b10110
) (
  input logic           clk,
  input logic           rst_n_q,
  input logic           br_valid,
  input logic           br_taken,
  input logic           pred_taken,
  input logic [LEN-1:0] ring
);
  localparam int unsigned ONES = $countones(PAT);

  // R5: idle cycles leave the stored sequence untouched
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n_q)
    !br_valid |=> $stable(ring));

  // R3: a hit brings the second stored bit to the head unchanged
  a_r3_hit_rotate: assert property (@(posedge clk) disable iff (!rst_n_q)
    (br_valid && (br_taken == pred_taken)) |=> (pred_taken == $past(ring[LEN-2])));

  // R4: a miss brings the complement of the second stored bit to the head
  a_r4_miss_flip: assert property (@(posedge clk) disable iff (!rst_n_q)
    (br_valid && (br_taken != pred_taken)) |=> (pred_taken != $past(ring[LEN-2])));

  // R8: the population of ones stays that of the pattern or its complement
  a_r8_ones_count: assert property (@(posedge clk) disable iff (!rst_n_q)
    ($countones(ring) == ONES) || ($countones(ring) == (LEN - ONES)));

  // R2: output follows the head
  a_r2_head_out: assert property (@(posedge clk) disable iff (!rst_n_q)
    pred_taken == ring[LEN-1]);
endmodule

bind periodic_branch_predictor periodic_branch_predictor_chk #(
  .LEN (PAT_LEN),
  .PAT (PAT)
) u_chk (
  .clk        (clk),
  .rst_n_q    (rst_n_q),
  .br_valid   (br_valid),
  .br_taken   (br_taken),
  .pred_taken (pred_taken),
  .ring       (ring_state)
);

// File: tb/test_periodic_branch_predictor.sv
`timescale 1ns/1ps
module test_periodic_branch_predictor;
  logic clk = 1'b0;
  logic rst_n;
  logic br_valid;
  logic br_taken;
  logic pred_taken;

  int total = 0;
  int bad   = 0;
  int misses = 0;

  bit exp_q[$];
  bit seq[5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  int idx;
  bit inv;
  string tag;

  always #10 clk = ~clk;

  periodic_branch_predictor i_periodic_branch_predictor (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_valid   (br_valid),
    .br_taken   (br_taken),
    .pred_taken (pred_taken)
  );

  function automatic bit model_pred();
    return seq[idx] ^ inv;
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: raise strobe and push the expected prediction.
  task automatic branch(input bit t);
    bit e;
    @(negedge clk);
    e = model_pred();
    exp_q.push_back(e);
    br_valid = 1'b1;
    br_taken = t;
    if (t != e) inv = ~inv;
    idx = (idx + 1) % 5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      br_valid = 1'b0;
      br_taken = ~br_taken;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    br_valid = 1'b0;
    rst_n = 1'b0;
    idx = 0;
    inv = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each strobed prediction before its consuming edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (br_valid) begin
        bit e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 queue empty", 0, 1);
        end else begin
          e = exp_q.pop_front();
          check(pred_taken == e, tag, pred_taken, e);
        end
        if (pred_taken != br_taken) misses++;
      end
    end
  end

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    br_valid = 1'b0;
    br_taken = 1'b0;
    idx = 0;
    inv = 1'b0;
    tag = "R1";
    #25;
    check(pred_taken == 1'b1, "R1 during reset", pred_taken, 1);
    do_reset();
    check(pred_taken == 1'b1, "R1 after reset", pred_taken, 1);

    // R2, R3, R6: stored sequence, three periods
    tag = "R6/R3 stored sequence";
    misses = 0;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 5; k++) branch(seq[k]);
    idle(1);
    check(misses == 0, "R6 miss count", misses, 0);

    // R7, R4: complemented sequence after reset
    do_reset();
    tag = "R7/R4 complemented sequence";
    misses = 0;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 5; k++) branch(~seq[k]);
    idle(1);
    check(misses == 1, "R7 miss count", misses, 1);

    // R5: idle with toggling outcome holds state
    branch(1'b1);
    branch(1'b0);
    idle(6);
    #5;
    check(pred_taken == model_pred(), "R5 hold after idle", pred_taken, model_pred());
    tag = "R5 resume after idle";
    for (int k = 0; k < 7; k++) branch(k[0]);
    idle(2);

    // R1: mid-stream reset reloads the stored sequence
    do_reset();
    check(pred_taken == 1'b1, "R1 mid-stream reset", pred_taken, 1);

    // R4, R8: mixed outcomes
    tag = "R4/R8 mixed outcomes";
    for (int k = 0; k < 40; k++) branch(((k * 7) % 3) == 1);
    idle(2);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule